// File: doc/BRIEF.md
# Addressed display packet protocol controller

This block sits behind the byte-framing layer of one display module on a shared multi-drop serial bus. The framing layer hands it each decoded packet as a one-cycle strobe. The strobe carries the payload length, the first payload byte and the first four payload bytes packed into a 32-bit word. The controller classifies each packet by its length alone. An empty packet is a discovery probe, one byte is a command, four bytes are an address, and a packet of exactly `HALF_LEN` bytes is one half of a frame-buffer image. It keeps a small state machine that records whether this module is currently selected.

A frame image arrives as two half-size packets in a row after a matching address. After the first half, the controller points the receive-store offset at the second half of the buffer. After the second half, it asks the frame formatter to run, provided the frame buffer is free; if the buffer is busy, it counts an overrun instead. Any malformed or unexpected packet drops the machine into an ignoring state. It stays there until a valid address selects it again. Discovery probes are answered only during a short window after reset.

The controller also keeps two saturating error counters and drives three indicator lamps: communication, error and identify. Each lamp is held lit for a fixed number of milliseconds after its most recent trigger. The millisecond time base is derived internally from the clock.

Top module: `disp_proto_ctrl`

## Requirements
- R1: After reset the machine is in the ignoring state. `store_base` is 0, both counters are 0, all three lamps are off and no request pulse is high.
- R2: A zero-length packet pulses `disc_reply` for one cycle, in the cycle after the strobe, only while fewer than `DISC_MS` milliseconds have passed since reset. It does not change the machine state.
- R3: A 4-byte packet whose word equals `dev_mac` selects the module. A 4-byte packet with any other word puts the machine into the ignoring state.
- R4: A 1-byte packet while selected pulses `status_req` if the byte is 0x01 and does nothing if it is any other value. Either way the machine then ignores further packets.
- R5: A 1-byte packet while not selected adds one to `invalid_cnt`, triggers the error lamp and leaves the machine ignoring.
- R6: A `HALF_LEN`-byte packet while selected moves the machine to wait for the second half and sets `store_base` to `HALF_LEN`. Every other packet sets `store_base` to 0.
- R7: A `HALF_LEN`-byte packet while waiting for the second half pulses `format_req` and triggers the identify lamp when `fb_ready` is 1. When `fb_ready` is 0 it instead adds one to `overrun_cnt` and triggers the error lamp. In both cases the machine then ignores.
- R8: A `HALF_LEN`-byte packet while ignoring changes no output other than the communication lamp.
- R9: A packet of any length other than 0, 1, 4 or `HALF_LEN` adds one to `invalid_cnt`, triggers the error lamp and makes the machine ignore.
- R10: Every packet triggers the communication lamp.
- R11: A lamp lights two cycles after the strobe of a packet that triggers it. It stays lit until between `HOLD_MS`-1 and `HOLD_MS` milliseconds after its last trigger, then goes dark.
- R12: Both counters are `COUNT_W` bits wide (32 by default) and stop at their all-ones value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid | input | 1 | One-cycle strobe: a decoded packet is complete |
| pkt_len | input | LEN_W | Payload length of the packet |
| pkt_byte | input | 8 | First payload byte |
| pkt_word | input | 32 | First four payload bytes as one word |
| dev_mac | input | 32 | This module's bus address |
| fb_ready | input | 1 | Frame buffer free to accept a new image |
| store_base | output | BASE_W | Offset where the next payload is stored |
| disc_reply | output | 1 | Pulse: send the address as a discovery reply |
| status_req | output | 1 | Pulse: send a status reply |
| format_req | output | 1 | Pulse: a complete image is ready to format |
| led_comm | output | 1 | Communication lamp |
| led_err | output | 1 | Error lamp |
| led_id | output | 1 | Identify lamp |
| overrun_cnt | output | COUNT_W | Saturating frame-overrun count |
| invalid_cnt | output | COUNT_W | Saturating invalid-packet count |

## Verification
The bench runs the full two-half image transfer and then sends a third half packet. A design that forgot to fall back to ignoring would format a second image. It sends commands outside the selected state and valid commands right after a consumed command. A machine that stayed selected would raise `status_req` twice where one is due. It checks that a bad length between an address and a half packet cancels the redirect, and that `store_base` returns to 0 after every non-redirecting packet. It also sends discovery probes on both sides of the uptime window, times a lamp across its hold interval from both ends, and drives the narrowed invalid counter past its top to catch wrapping.

// File: rtl/disp_proto_pkg.sv
package disp_proto_pkg;

    typedef enum logic [1:0] {
        ST_SELECTED = 2'd0,
        ST_WAIT_H2  = 2'd1,
        ST_IGNORE   = 2'd2
    } sel_state_e;

    typedef struct packed {
        logic err;
        logic comm;
        logic ident;
    } lamp_trig_t;

    localparam int unsigned CMD_LEN     = 1;
    localparam int unsigned ADDR_LEN    = 4;
    localparam logic [7:0]  CMD_STATUS  = 8'h01;

endpackage

// File: rtl/disp_ms_base.sv
module disp_ms_base #(
    parameter int unsigned TICKS_PER_MS = 50000,
    parameter int unsigned DISC_MS      = 100
) (
    input  logic clk,
    input  logic rst,
    output logic ms_tick,
    output logic disc_open
);
    localparam int unsigned PW = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
    localparam int unsigned UW = $clog2(DISC_MS + 1);

    logic [PW-1:0] pre_q;
    logic [UW-1:0] up_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q   <= '0;
            ms_tick <= 1'b0;
        end else if (pre_q == PW'(TICKS_PER_MS - 1)) begin
            pre_q   <= '0;
            ms_tick <= 1'b1;
        end else begin
            pre_q   <= pre_q + 1'b1;
            ms_tick <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            up_q <= '0;
        else if (ms_tick && up_q != UW'(DISC_MS))
            up_q <= up_q + 1'b1;
    end

    assign disc_open = (up_q < UW'(DISC_MS));
endmodule

// File: rtl/disp_lamp_hold.sv
module disp_lamp_hold #(
    parameter int unsigned HOLD_MS = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    input  logic ms_tick,
    output logic lamp
);
    localparam int unsigned HW = $clog2(HOLD_MS + 1);

    logic [HW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst)
            left_q <= '0;
        else if (trig)
            left_q <= HW'(HOLD_MS);
        else if (ms_tick && left_q != '0)
            left_q <= left_q - 1'b1;
    end

    assign lamp = (left_q != '0);
endmodule

// File: rtl/disp_sel_fsm.sv
module disp_sel_fsm
    import disp_proto_pkg::*;
#(
    parameter int unsigned LEN_W    = 8,
    parameter int unsigned HALF_LEN = 80,
    parameter int unsigned COUNT_W  = 32,
    parameter int unsigned BASE_W   = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pkt_valid,
    input  logic [LEN_W-1:0]   pkt_len,
    input  logic [7:0]         pkt_byte,
    input  logic [31:0]        pkt_word,
    input  logic [31:0]        dev_mac,
    input  logic               fb_ready,
    input  logic               disc_open,
    output sel_state_e         state,
    output logic [BASE_W-1:0]  store_base,
    output logic               disc_reply,
    output logic               status_req,
    output logic               format_req,
    output lamp_trig_t         trig,
    output logic [COUNT_W-1:0] overrun_cnt,
    output logic [COUNT_W-1:0] invalid_cnt
);
    localparam logic [COUNT_W-1:0] CNT_TOP = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IGNORE;
            store_base  <= '0;
            disc_reply  <= 1'b0;
            status_req  <= 1'b0;
            format_req  <= 1'b0;
            trig        <= '0;
            overrun_cnt <= '0;
            invalid_cnt <= '0;
        end else begin
            disc_reply <= 1'b0;
            status_req <= 1'b0;
            format_req <= 1'b0;
            trig       <= '0;
            if (pkt_valid) begin
                trig.comm  <= 1'b1;
                store_base <= '0;
                if (pkt_len == '0) begin
                    disc_reply <= disc_open;
                end else if (pkt_len == LEN_W'(CMD_LEN)) begin
                    if (state == ST_SELECTED) begin
                        status_req <= (pkt_byte == CMD_STATUS);
                    end else begin
                        trig.err <= 1'b1;
                        if (invalid_cnt != CNT_TOP)
                            invalid_cnt <= invalid_cnt + 1'b1;
                    end
                    state <= ST_IGNORE;
                end else if (pkt_len == LEN_W'(ADDR_LEN)) begin
                    state <= (pkt_word == dev_mac) ? ST_SELECTED : ST_IGNORE;
                end else if (pkt_len == LEN_W'(HALF_LEN)) begin
                    if (state == ST_SELECTED) begin
                        state      <= ST_WAIT_H2;
                        store_base <= BASE_W'(HALF_LEN);
                    end else if (state == ST_WAIT_H2) begin
                        if (fb_ready) begin
                            format_req <= 1'b1;
                            trig.ident <= 1'b1;
                        end else begin
                            trig.err <= 1'b1;
                            if (overrun_cnt != CNT_TOP)
                                overrun_cnt <= overrun_cnt + 1'b1;
                        end
                        state <= ST_IGNORE;
                    end
                end else begin
                    trig.err <= 1'b1;
                    if (invalid_cnt != CNT_TOP)
                        invalid_cnt <= invalid_cnt + 1'b1;
                    state <= ST_IGNORE;
                end
            end
        end
    end
endmodule

// File: rtl/disp_proto_ctrl.sv
module disp_proto_ctrl
    import disp_proto_pkg::*;
#(
    parameter int unsigned LEN_W        = 8,
    parameter int unsigned HALF_LEN     = 80,
    parameter int unsigned COUNT_W      = 32,
    parameter int unsigned TICKS_PER_MS = 50000,
    parameter int unsigned HOLD_MS      = 50,
    parameter int unsigned DISC_MS      = 100,
    localparam int unsigned BASE_W      = $clog2(HALF_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pkt_valid,
    input  logic [LEN_W-1:0]   pkt_len,
    input  logic [7:0]         pkt_byte,
    input  logic [31:0]        pkt_word,
    input  logic [31:0]        dev_mac,
    input  logic               fb_ready,
    output logic [BASE_W-1:0]  store_base,
    output logic               disc_reply,
    output logic               status_req,
    output logic               format_req,
    output logic               led_comm,
    output logic               led_err,
    output logic               led_id,
    output logic [COUNT_W-1:0] overrun_cnt,
    output logic [COUNT_W-1:0] invalid_cnt
);
    logic       ms_tick;
    logic       disc_open;
    sel_state_e sel_state;
    lamp_trig_t trig;
    logic [2:0] trig_v;
    logic [2:0] lamp_v;

    disp_ms_base #(.TICKS_PER_MS(TICKS_PER_MS), .DISC_MS(DISC_MS)) tb_i (
        .clk(clk), .rst(rst), .ms_tick(ms_tick), .disc_open(disc_open)
    );

    disp_sel_fsm #(
        .LEN_W(LEN_W), .HALF_LEN(HALF_LEN), .COUNT_W(COUNT_W), .BASE_W(BASE_W)
    ) fsm_i (
        .clk(clk), .rst(rst), .pkt_valid(pkt_valid), .pkt_len(pkt_len),
        .pkt_byte(pkt_byte), .pkt_word(pkt_word), .dev_mac(dev_mac),
        .fb_ready(fb_ready), .disc_open(disc_open), .state(sel_state),
        .store_base(store_base), .disc_reply(disc_reply), .status_req(status_req),
        .format_req(format_req), .trig(trig), .overrun_cnt(overrun_cnt),
        .invalid_cnt(invalid_cnt)
    );

    assign trig_v = {trig.err, trig.comm, trig.ident};

    for (genvar g = 0; g < 3; g++) begin : g_lamp
        disp_lamp_hold #(.HOLD_MS(HOLD_MS)) hold_i (
            .clk(clk), .rst(rst), .trig(trig_v[g]), .ms_tick(ms_tick), .lamp(lamp_v[g])
        );
    end

    assign led_err  = lamp_v[2];
    assign led_comm = lamp_v[1];
    assign led_id   = lamp_v[0];
endmodule

// File: rtl/disp_proto_chk.sv
module disp_proto_chk
    import disp_proto_pkg::*;
#(
    parameter int unsigned LEN_W   = 8,
    parameter int unsigned COUNT_W = 32,
    parameter int unsigned BASE_W  = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               pkt_valid,
    input sel_state_e         sel_state,
    input logic [BASE_W-1:0]  store_base,
    input logic               disc_reply,
    input logic               status_req,
    input logic               format_req,
    input logic               led_comm,
    input logic [COUNT_W-1:0] overrun_cnt,
    input logic [COUNT_W-1:0] invalid_cnt
);
    // R10
    comm_lamp_after_pkt_chk: assert property (@(posedge clk) disable iff (rst)
        pkt_valid |=> ##1 led_comm);

    // R6
    redirect_only_waiting_chk: assert property (@(posedge clk) disable iff (rst)
        (store_base != '0) |-> (sel_state == ST_WAIT_H2));

    // R7
    format_from_wait_chk: assert property (@(posedge clk) disable iff (rst)
        format_req |-> ($past(sel_state) == ST_WAIT_H2 && sel_state == ST_IGNORE));

    // R4
    status_from_selected_chk: assert property (@(posedge clk) disable iff (rst)
        status_req |-> ($past(sel_state) == ST_SELECTED && sel_state == ST_IGNORE));

    // R2
    disc_alone_chk: assert property (@(posedge clk) disable iff (rst)
        disc_reply |-> (!status_req && !format_req && $stable(sel_state)));

    // R12
    counters_monotonic_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (invalid_cnt >= $past(invalid_cnt) && overrun_cnt >= $past(overrun_cnt)));
endmodule

bind disp_proto_ctrl disp_proto_chk #(
    .LEN_W(LEN_W), .COUNT_W(COUNT_W), .BASE_W(BASE_W)
) chk_i (
    .clk(clk), .rst(rst), .pkt_valid(pkt_valid), .sel_state(sel_state),
    .store_base(store_base), .disc_reply(disc_reply), .status_req(status_req),
    .format_req(format_req), .led_comm(led_comm), .overrun_cnt(overrun_cnt),
    .invalid_cnt(invalid_cnt)
);

// File: tb/disp_proto_ctrl_tb_top.sv
module disp_proto_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W = 8;
    localparam int HALF_LEN = 80;
    localparam int COUNT_W = 4;
    localparam int TPM = 4;
    localparam int HOLD_MS = 50;
    localparam int DISC_MS = 100;
    localparam int BASE_W = $clog2(HALF_LEN + 1);
    localparam logic [31:0] MAC = 32'hC0FFEE42;

    logic clk = 0, rst = 1;
    logic pkt_valid = 0;
    logic [LEN_W-1:0] pkt_len = '0;
    logic [7:0] pkt_byte = '0;
    logic [31:0] pkt_word = '0;
    logic fb_ready = 1;
    logic [BASE_W-1:0] store_base;
    logic disc_reply, status_req, format_req, led_comm, led_err, led_id;
    logic [COUNT_W-1:0] overrun_cnt, invalid_cnt;

    int n_chk = 0, n_bad = 0;
    int exp_inv = 0, exp_ovr = 0;
    logic p_disc, p_stat, p_fmt;
    logic done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    disp_proto_ctrl #(
        .LEN_W(LEN_W), .HALF_LEN(HALF_LEN), .COUNT_W(COUNT_W),
        .TICKS_PER_MS(TPM), .HOLD_MS(HOLD_MS), .DISC_MS(DISC_MS)
    ) dut_i (
        .clk(clk), .rst(rst), .pkt_valid(pkt_valid), .pkt_len(pkt_len),
        .pkt_byte(pkt_byte), .pkt_word(pkt_word), .dev_mac(MAC), .fb_ready(fb_ready),
        .store_base(store_base), .disc_reply(disc_reply), .status_req(status_req),
        .format_req(format_req), .led_comm(led_comm), .led_err(led_err), .led_id(led_id),
        .overrun_cnt(overrun_cnt), .invalid_cnt(invalid_cnt)
    );

    task automatic check(string req, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic send(int len, logic [7:0] b, logic [31:0] w);
        @(negedge clk);
        pkt_valid = 1; pkt_len = LEN_W'(len); pkt_byte = b; pkt_word = w;
        @(negedge clk);
        pkt_valid = 0;
        p_disc = disc_reply; p_stat = status_req; p_fmt = format_req;
    endtask

    task automatic bump_inv();
        if (exp_inv < 15) exp_inv++;
    endtask

    task automatic t_reset();
        check("R1 base", store_base, 0);
        check("R1 pulses", {disc_reply, status_req, format_req}, 0);
        check("R1 lamps", {led_comm, led_err, led_id}, 0);
        check("R1 counters", {overrun_cnt, invalid_cnt}, 0);
    endtask

    task automatic t_disc_early();
        send(0, 8'h00, 32'h0);
        check("R2 early reply", p_disc, 1);
        @(negedge clk);
        check("R10 comm lamp", led_comm, 1);
        check("R2 reply one cycle", disc_reply, 0);
    endtask

    task automatic t_cmd_unselected();
        send(4, 8'h00, MAC ^ 32'h1);
        send(1, 8'h01, 32'h0);
        bump_inv();
        check("R3/R5 no status when unselected", p_stat, 0);
        check("R5 invalid count", invalid_cnt, exp_inv);
        @(negedge clk);
        check("R5 error lamp", led_err, 1);
    endtask

    task automatic t_cmd_selected();
        send(4, 8'h00, MAC);
        send(1, 8'h01, 32'h0);
        check("R4 status pulse", p_stat, 1);
        check("R4 no invalid", invalid_cnt, exp_inv);
        send(1, 8'h01, 32'h0);
        bump_inv();
        check("R4 ignoring after command", p_stat, 0);
        check("R5 invalid after command", invalid_cnt, exp_inv);
        send(4, 8'h00, MAC);
        send(1, 8'h05, 32'h0);
        check("R4 other byte no status", p_stat, 0);
        check("R4 other byte no invalid", invalid_cnt, exp_inv);
    endtask

    task automatic t_frame_ok();
        send(4, 8'h00, MAC);
        send(HALF_LEN, 8'h00, 32'h0);
        check("R6 redirect", store_base, HALF_LEN);
        fb_ready = 1;
        send(HALF_LEN, 8'h00, 32'h0);
        check("R7 format pulse", p_fmt, 1);
        check("R6 base back to 0", store_base, 0);
        @(negedge clk);
        check("R7 identify lamp", led_id, 1);
        send(HALF_LEN, 8'h00, 32'h0);
        check("R8 no second format", p_fmt, 0);
        check("R8 base stays 0", store_base, 0);
        check("R8 counters unchanged", {overrun_cnt, invalid_cnt}, {COUNT_W'(exp_ovr), COUNT_W'(exp_inv)});
    endtask

    task automatic t_frame_overrun();
        send(4, 8'h00, MAC);
        send(HALF_LEN, 8'h00, 32'h0);
        fb_ready = 0;
        send(HALF_LEN, 8'h00, 32'h0);
        exp_ovr++;
        check("R7 no format when busy", p_fmt, 0);
        check("R7 overrun count", overrun_cnt, exp_ovr);
        fb_ready = 1;
    endtask

    task automatic t_bad_len();
        send(4, 8'h00, MAC);
        send(7, 8'h00, 32'h0);
        bump_inv();
        check("R9 invalid count", invalid_cnt, exp_inv);
        send(HALF_LEN, 8'h00, 32'h0);
        check("R9 no redirect after bad length", store_base, 0);
    endtask

    task automatic t_lamp_hold();
        repeat ((HOLD_MS + 2) * TPM) @(negedge clk);
        check("R11 error lamp dark before", led_err, 0);
        send(9, 8'h00, 32'h0);
        bump_inv();
        @(negedge clk);
        check("R11 error lamp lit", led_err, 1);
        repeat ((HOLD_MS - 2) * TPM) @(negedge clk);
        check("R11 still lit", led_err, 1);
        repeat (3 * TPM) @(negedge clk);
        check("R11 dark after hold", led_err, 0);
    endtask

    task automatic t_disc_late();
        repeat ((DISC_MS + 2) * TPM) @(negedge clk);
        send(0, 8'h00, 32'h0);
        check("R2 no late reply", p_disc, 0);
    endtask

    task automatic t_saturate();
        for (int i = 0; i < 20; i++) begin
            send(3, 8'h00, 32'h0);
            bump_inv();
        end
        check("R12 invalid saturates", invalid_cnt, 15);
        check("R12 model agrees", exp_inv, 15);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_disc_early();
        t_cmd_unselected();
        t_cmd_selected();
        t_frame_ok();
        t_frame_overrun();
        t_bad_len();
        t_lamp_hold();
        t_disc_late();
        t_saturate();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule